// File: doc/BRIEF.md
# Partition-Steered Node Wrapper

This block connects one host core to a flat, single-hop network in which nodes are grouped into partitions. For every partition in the network, including the node's own, there is one unidirectional subnet, and the wrapper has one transmit port and one receive port per subnet. To send, the host offers a message made of a destination node number and a payload. The wrapper works out which partition holds that node by comparing the number against a parameter table of partition base numbers. Partitions may differ in size. The message is then steered onto the transmit port of that partition only, and the host waits until that port takes it.

A subnet delivers each message to every node of its destination partition. The receive side therefore sees traffic meant for its neighbours as well as its own. Each cycle a round-robin arbiter picks one delivering subnet, starting at the subnet just after the one it last served. The arbiter classifies the outcome as ARB_NONE (nothing offered), ARB_DROP (not addressed to this node: acknowledged and discarded), ARB_STORE (addressed here and there is room: acknowledged and written into the receive FIFO) or ARB_BLOCK (addressed here but the FIFO is full: left waiting). Subnets that were not picked stay waiting. The host drains the FIFO with a valid/ready handshake.

Top module: `xnw_node_wrap`

## Requirements
- R1: While reset is held and on the first cycle after it, host_rx_valid is 0, and no subnet transmit valid or receive ready is high when no input offers anything.
- R2: With host_tx_valid high, exactly one bit of sub_tx_valid is high: bit p, where p is the highest partition index whose base number (default bases 0, 5, 9 for partitions 0, 1, 2) is less than or equal to host_tx_dst.
- R3: host_tx_ready equals sub_tx_ready[p] for the selected partition p, so the host stalls until that port accepts. With host_tx_valid low, all sub_tx_valid bits are 0.
- R4: sub_tx_dst and sub_tx_data carry host_tx_dst and host_tx_data unchanged.
- R5: A receive message whose destination differs from MY_ID (default 6) is acknowledged through sub_rx_ready in the cycle it wins arbitration, and it never appears on host_rx_data.
- R6: A receive message addressed to MY_ID is acknowledged when it wins and there is room in the FIFO. It appears on host_rx_valid/host_rx_data from the next cycle, stays stable while host_rx_ready is low, and messages leave in the order they were stored.
- R7: At most one sub_rx_ready bit is high per cycle, only for a valid subnet. The winner is the first valid subnet scanning upward, with wrap-around, from the index after the last acknowledged subnet. The scan starts at 0 after reset.
- R8: While the FIFO is full, a matching winner gets no ready and waits. A non-matching winner is still acknowledged and dropped. The waiting message is stored in the cycle after the host frees a slot.
- R9: The FIFO holds RX_DEPTH (default 4) messages, and all of them are delivered in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_tx_valid | input | 1 | Host offers an outgoing message |
| host_tx_ready | output | 1 | Selected subnet port accepted the message |
| host_tx_dst | input | NODE_W | Destination node number |
| host_tx_data | input | DATA_W | Outgoing payload |
| sub_tx_valid | output | NUM_PART | Per-subnet transmit valid, at most one high |
| sub_tx_ready | input | NUM_PART | Per-subnet transmit ready |
| sub_tx_dst | output | NODE_W | Destination number shared by all transmit ports |
| sub_tx_data | output | DATA_W | Payload shared by all transmit ports |
| sub_rx_valid | input | NUM_PART | Per-subnet receive valid |
| sub_rx_ready | output | NUM_PART | Per-subnet receive acknowledge |
| sub_rx_dst | input | NUM_PART x NODE_W | Destination number on each receive subnet |
| sub_rx_data | input | NUM_PART x DATA_W | Payload on each receive subnet |
| host_rx_valid | output | 1 | Buffered message available to the host |
| host_rx_ready | input | 1 | Host takes the buffered message |
| host_rx_data | output | DATA_W | Buffered payload |

## Verification
Two receive functions can meet in one cycle: several subnets delivering at once, and a delivery arriving while the FIFO is full. The bench provokes the first by raising all three receive valids together, and the pair 0 and 2 together, from known pointer positions. It checks the grant order cycle by cycle against the wrap-around scan. It provokes the second by filling the FIFO and then offering a matching and a non-matching message together. It judges that the non-matching one is dropped, the matching one waits with no ready until a slot is freed, and the drained order proves no loss. The transmit mapping is swept over every destination number and every ready pattern, with the expected partition computed from the base numbers.

// File: rtl/xnw_pkg.sv
package xnw_pkg;

    typedef enum logic [1:0] {
        ARB_NONE,
        ARB_DROP,
        ARB_STORE,
        ARB_BLOCK
    } arb_outcome_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/xnw_part_map.sv
module xnw_part_map #(
    parameter int NP     = 3,
    parameter int NODE_W = 4,
    parameter int PW     = 2,
    parameter logic [NP-1:0][NODE_W-1:0] PART_BASE = '0
) (
    input  logic [NODE_W-1:0] node_id,
    output logic [PW-1:0]     part_idx
);

    // highest partition whose base does not exceed the node number
    always_comb begin
        part_idx = '0;
        for (int i = 0; i < NP; i++) begin
            if (node_id >= PART_BASE[i]) begin
                part_idx = PW'(i);
            end
        end
    end

endmodule

// File: rtl/xnw_tx_route.sv
module xnw_tx_route #(
    parameter int NP     = 3,
    parameter int NODE_W = 4,
    parameter int DATA_W = 8,
    parameter int PW     = 2
) (
    input  logic              host_tx_valid,
    output logic              host_tx_ready,
    input  logic [NODE_W-1:0] host_tx_dst,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic [PW-1:0]     part_idx,
    output logic [NP-1:0]     sub_tx_valid,
    input  logic [NP-1:0]     sub_tx_ready,
    output logic [NODE_W-1:0] sub_tx_dst,
    output logic [DATA_W-1:0] sub_tx_data
);

    generate
        for (genvar g = 0; g < NP; g++) begin : g_lane
            assign sub_tx_valid[g] = host_tx_valid && (part_idx == PW'(g));
        end
    endgenerate

    always_comb begin
        host_tx_ready = 1'b0;
        for (int i = 0; i < NP; i++) begin
            if (part_idx == PW'(i)) begin
                host_tx_ready = sub_tx_ready[i];
            end
        end
    end

    assign sub_tx_dst  = host_tx_dst;
    assign sub_tx_data = host_tx_data;

endmodule

// File: rtl/xnw_rx_arb.sv
module xnw_rx_arb
    import xnw_pkg::*;
#(
    parameter int NP     = 3,
    parameter int NODE_W = 4,
    parameter int DATA_W = 8,
    parameter int PW     = 2,
    parameter logic [NODE_W-1:0] MY_ID = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NP-1:0]                sub_rx_valid,
    output logic [NP-1:0]                sub_rx_ready,
    input  logic [NP-1:0][NODE_W-1:0]    sub_rx_dst,
    input  logic [NP-1:0][DATA_W-1:0]    sub_rx_data,
    input  logic                         fifo_full,
    output logic                         wr_en,
    output logic [DATA_W-1:0]            wr_data
);

    logic [PW-1:0]  rr_ptr;
    logic [PW-1:0]  win;
    logic           found;
    logic           match;
    arb_outcome_e   outcome;

    // circular scan from the pointer
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < NP; k++) begin
            int idx;
            idx = int'(rr_ptr) + k;
            if (idx >= NP) idx = idx - NP;
            if (!found && sub_rx_valid[idx]) begin
                found = 1'b1;
                win   = PW'(idx);
            end
        end
    end

    assign match   = (sub_rx_dst[win] == MY_ID);
    assign wr_data = sub_rx_data[win];

    always_comb begin
        if (!found)         outcome = ARB_NONE;
        else if (!match)    outcome = ARB_DROP;
        else if (fifo_full) outcome = ARB_BLOCK;
        else                outcome = ARB_STORE;
    end

    always_comb begin
        sub_rx_ready = '0;
        wr_en        = 1'b0;
        unique case (outcome)
            ARB_NONE:  ;
            ARB_DROP:  sub_rx_ready[win] = 1'b1;
            ARB_STORE: begin
                sub_rx_ready[win] = 1'b1;
                wr_en             = 1'b1;
            end
            ARB_BLOCK: ;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (outcome == ARB_DROP || outcome == ARB_STORE) begin
            rr_ptr <= (win == PW'(NP - 1)) ? '0 : win + 1'b1;
        end
    end

    AST_RX_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sub_rx_ready)) else $error("two receive grants"); // R7

    AST_RX_GRANT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_rx_ready & ~sub_rx_valid) == '0) else $error("grant without valid"); // R7

endmodule

// File: rtl/xnw_rx_fifo.sv
module xnw_rx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              rd_en;

    assign full      = (count == CW'(DEPTH));
    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign rd_en     = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full) else $error("write into full buffer"); // R8

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
        else $error("offered message changed"); // R6

endmodule

// File: rtl/xnw_node_wrap.sv
module xnw_node_wrap
    import xnw_pkg::*;
#(
    parameter int NUM_PART = 3,
    parameter int NODE_W   = 4,
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 4,
    parameter logic [NODE_W-1:0] MY_ID = 4'd6,
    parameter logic [NUM_PART-1:0][NODE_W-1:0] PART_BASE = {4'd9, 4'd5, 4'd0},
    localparam int PW = idx_width(NUM_PART)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              host_tx_valid,
    output logic                              host_tx_ready,
    input  logic [NODE_W-1:0]                 host_tx_dst,
    input  logic [DATA_W-1:0]                 host_tx_data,
    output logic [NUM_PART-1:0]               sub_tx_valid,
    input  logic [NUM_PART-1:0]               sub_tx_ready,
    output logic [NODE_W-1:0]                 sub_tx_dst,
    output logic [DATA_W-1:0]                 sub_tx_data,
    input  logic [NUM_PART-1:0]               sub_rx_valid,
    output logic [NUM_PART-1:0]               sub_rx_ready,
    input  logic [NUM_PART-1:0][NODE_W-1:0]   sub_rx_dst,
    input  logic [NUM_PART-1:0][DATA_W-1:0]   sub_rx_data,
    output logic                              host_rx_valid,
    input  logic                              host_rx_ready,
    output logic [DATA_W-1:0]                 host_rx_data
);

    logic [PW-1:0]     tx_part;
    logic              fifo_full;
    logic              fifo_wr;
    logic [DATA_W-1:0] fifo_wdata;

    xnw_part_map #(
        .NP(NUM_PART), .NODE_W(NODE_W), .PW(PW), .PART_BASE(PART_BASE)
    ) u_map (
        .node_id  (host_tx_dst),
        .part_idx (tx_part)
    );

    xnw_tx_route #(
        .NP(NUM_PART), .NODE_W(NODE_W), .DATA_W(DATA_W), .PW(PW)
    ) u_tx (
        .host_tx_valid (host_tx_valid),
        .host_tx_ready (host_tx_ready),
        .host_tx_dst   (host_tx_dst),
        .host_tx_data  (host_tx_data),
        .part_idx      (tx_part),
        .sub_tx_valid  (sub_tx_valid),
        .sub_tx_ready  (sub_tx_ready),
        .sub_tx_dst    (sub_tx_dst),
        .sub_tx_data   (sub_tx_data)
    );

    xnw_rx_arb #(
        .NP(NUM_PART), .NODE_W(NODE_W), .DATA_W(DATA_W), .PW(PW), .MY_ID(MY_ID)
    ) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .sub_rx_valid (sub_rx_valid),
        .sub_rx_ready (sub_rx_ready),
        .sub_rx_dst   (sub_rx_dst),
        .sub_rx_data  (sub_rx_data),
        .fifo_full    (fifo_full),
        .wr_en        (fifo_wr),
        .wr_data      (fifo_wdata)
    );

    xnw_rx_fifo #(
        .DATA_W(DATA_W), .DEPTH(RX_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (fifo_wr),
        .wr_data   (fifo_wdata),
        .full      (fifo_full),
        .out_valid (host_rx_valid),
        .out_ready (host_rx_ready),
        .out_data  (host_rx_data)
    );

    AST_TX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sub_tx_valid)) else $error("message on two subnets"); // R2

    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !host_tx_valid |-> (sub_tx_valid == '0)) else $error("spurious transmit"); // R3

endmodule

// File: tb/sim_xnw_node_wrap.sv
module sim_xnw_node_wrap;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;
    localparam int NW = 4;
    localparam int DW = 8;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     host_tx_valid = 1'b0;
    logic                     host_tx_ready;
    logic [NW-1:0]            host_tx_dst = '0;
    logic [DW-1:0]            host_tx_data = '0;
    logic [NP-1:0]            sub_tx_valid;
    logic [NP-1:0]            sub_tx_ready = '0;
    logic [NW-1:0]            sub_tx_dst;
    logic [DW-1:0]            sub_tx_data;
    logic [NP-1:0]            sub_rx_valid = '0;
    logic [NP-1:0]            sub_rx_ready;
    logic [NP-1:0][NW-1:0]    sub_rx_dst = '0;
    logic [NP-1:0][DW-1:0]    sub_rx_data = '0;
    logic                     host_rx_valid;
    logic                     host_rx_ready = 1'b0;
    logic [DW-1:0]            host_rx_data;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xnw_node_wrap u0 (
        .clk(clk), .rst_n(rst_n),
        .host_tx_valid(host_tx_valid), .host_tx_ready(host_tx_ready),
        .host_tx_dst(host_tx_dst), .host_tx_data(host_tx_data),
        .sub_tx_valid(sub_tx_valid), .sub_tx_ready(sub_tx_ready),
        .sub_tx_dst(sub_tx_dst), .sub_tx_data(sub_tx_data),
        .sub_rx_valid(sub_rx_valid), .sub_rx_ready(sub_rx_ready),
        .sub_rx_dst(sub_rx_dst), .sub_rx_data(sub_rx_data),
        .host_rx_valid(host_rx_valid), .host_rx_ready(host_rx_ready),
        .host_rx_data(host_rx_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_part(input int d);
        int p;
        p = 0;
        if (d >= 5) p = 1;
        if (d >= 9) p = 2;
        return p;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int order [3];

        // reset (R1)
        @(negedge clk);
        chk(host_rx_valid == 1'b0, "R1 rx valid in reset", int'(host_rx_valid), 0);
        step();
        rst_n = 1'b1;
        #1;
        chk(host_rx_valid == 1'b0, "R1 rx valid after reset", int'(host_rx_valid), 0);
        chk(sub_tx_valid == '0, "R1 tx valid idle", int'(sub_tx_valid), 0);
        chk(sub_rx_ready == '0, "R1 rx ready idle", int'(sub_rx_ready), 0);
        @(negedge clk);

        // transmit sweep: every destination, every ready pattern (R2 R3 R4)
        for (int d = 0; d < 16; d++) begin
            for (int r = 0; r < 8; r++) begin
                int p;
                p = exp_part(d);
                host_tx_valid = 1'b1;
                host_tx_dst   = NW'(d);
                host_tx_data  = DW'(d * 7 + r);
                sub_tx_ready  = NP'(r);
                #1;
                chk(sub_tx_valid == NP'(1 << p), "R2 subnet select", int'(sub_tx_valid), 1 << p);
                chk(host_tx_ready == 1'((r >> p) & 1), "R3 ready follows port",
                    int'(host_tx_ready), (r >> p) & 1);
                chk(sub_tx_dst == NW'(d) && sub_tx_data == DW'(d * 7 + r), "R4 forwarded fields",
                    int'(sub_tx_data), d * 7 + r);
            end
        end
        host_tx_valid = 1'b0;
        #1;
        chk(sub_tx_valid == '0, "R3 no valid without host", int'(sub_tx_valid), 0);
        @(negedge clk);

        // receive filter sweep on subnet 1 (R5 R6)
        for (int d = 0; d < 16; d++) begin
            sub_rx_valid   = 3'b010;
            sub_rx_dst[1]  = NW'(d);
            sub_rx_data[1] = DW'(8'h40 + d);
            #1;
            chk(sub_rx_ready == 3'b010, "R5 acknowledge on filter", int'(sub_rx_ready), 2);
            step();
            sub_rx_valid = '0;
            #1;
            chk(host_rx_valid == (d == 6), "R5 only own id stored", int'(host_rx_valid), int'(d == 6));
            if (host_rx_valid) begin
                chk(host_rx_data == 8'h46, "R6 stored payload", int'(host_rx_data), 8'h46);
                host_rx_ready = 1'b1;
                step();
                host_rx_ready = 1'b0;
                #1;
                chk(host_rx_valid == 1'b0, "R6 popped", int'(host_rx_valid), 0);
            end
            @(negedge clk);
        end

        // round robin, pointer at 2 after last grant on subnet 1 (R7)
        order[0] = 2; order[1] = 0; order[2] = 1;
        for (int i = 0; i < NP; i++) begin
            sub_rx_dst[i]  = 4'd6;
            sub_rx_data[i] = DW'(8'h10 + i);
        end
        sub_rx_valid = 3'b111;
        for (int s = 0; s < 3; s++) begin
            #1;
            chk(sub_rx_ready == NP'(1 << order[s]), "R7 grant order", int'(sub_rx_ready), 1 << order[s]);
            step();
            sub_rx_valid[order[s]] = 1'b0;
        end
        host_rx_ready = 1'b1;
        for (int s = 0; s < 3; s++) begin
            #1;
            chk(host_rx_valid && host_rx_data == DW'(8'h10 + order[s]), "R6 arrival order",
                int'(host_rx_data), 8'h10 + order[s]);
            step();
        end
        host_rx_ready = 1'b0;
        #1;
        chk(host_rx_valid == 1'b0, "R6 drained", int'(host_rx_valid), 0);

        // wrap: pointer at 2, subnets 0 and 2 together -> 2 then 0 (R7)
        @(negedge clk);
        sub_rx_valid = 3'b101;
        #1;
        chk(sub_rx_ready == 3'b100, "R7 wrap first", int'(sub_rx_ready), 4);
        step();
        sub_rx_valid[2] = 1'b0;
        #1;
        chk(sub_rx_ready == 3'b001, "R7 wrap second", int'(sub_rx_ready), 1);
        step();
        sub_rx_valid = '0;
        host_rx_ready = 1'b1;
        #1;
        chk(host_rx_data == 8'h12, "R7 wrap data first", int'(host_rx_data), 8'h12);
        step();
        #1;
        chk(host_rx_data == 8'h10, "R7 wrap data second", int'(host_rx_data), 8'h10);
        step();
        host_rx_ready = 1'b0;

        // fill buffer through subnet 0, pointer ends at 1 (R8 R9)
        for (int k = 0; k < 4; k++) begin
            sub_rx_valid   = 3'b001;
            sub_rx_data[0] = DW'(8'h20 + k);
            step();
        end
        sub_rx_data[0] = 8'h24;
        sub_rx_dst[1]  = 4'd3;
        sub_rx_valid   = 3'b011;
        #1;
        chk(sub_rx_ready == 3'b010, "R8 mismatch drained while full", int'(sub_rx_ready), 2);
        step();
        sub_rx_valid = 3'b001;
        for (int w = 0; w < 2; w++) begin
            #1;
            chk(sub_rx_ready == 3'b000, "R8 match held while full", int'(sub_rx_ready), 0);
            step();
        end
        host_rx_ready = 1'b1;
        #1;
        chk(sub_rx_ready == 3'b000 && host_rx_data == 8'h20, "R9 oldest at head",
            int'(host_rx_data), 8'h20);
        step();
        host_rx_ready = 1'b0;
        #1;
        chk(sub_rx_ready == 3'b001, "R8 stored after slot frees", int'(sub_rx_ready), 1);
        step();
        sub_rx_valid = '0;
        host_rx_ready = 1'b1;
        for (int k = 1; k < 5; k++) begin
            #1;
            chk(host_rx_valid && host_rx_data == DW'(8'h20 + k), "R9 full depth order",
                int'(host_rx_data), 8'h20 + k);
            step();
        end
        host_rx_ready = 1'b0;
        #1;
        chk(host_rx_valid == 1'b0, "R9 empty at end", int'(host_rx_valid), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule